// File: doc/BRIEF.md
# Storage PHY Power Sequencer

This block is a hardware state machine that brings the analog front end of a managed-flash storage PHY up and down, a job that would otherwise fall to a software routine polling status bits. A single-cycle request strobe carries a direction bit, on or off. Whatever the direction, the sequencer first forces the power-down-bar and DLL-enable lines low so that the calibration logic inside the PHY can initialise. An off request ends right there.

An on request then walks a fixed bring-up order. The internal clock is enabled first, and the sequencer waits for the clock-ready status. The clock output is enabled next. After a settling interval, power-down-bar is released, and after a calibration interval the sequencer samples calibration-done. It then raises DLL-enable, waits a lock interval and samples DLL-ready. Every interval is a parameter counted in clock cycles.

When the sequence ends, the block raises `done` together with a two-bit result code that names the step that failed, if any. The code is held until the next accepted request. Requests that arrive while the sequencer is busy are dropped.

Top module: `phy_pwr_seq`

## Requirements
- R1: After a synchronous reset all outputs are low and `fail_code_o` is 0.
- R2: A request taken while `busy_o` is low (`req_stb_i` high, either value of `req_on_i`) produces, on the next edge: `busy_o` high, `done_o` low, `fail_code_o` 0, `pdb_o` and `endll_o` low. An on request also clears `clk_out_en_o` on that edge.
- R3: An off request (`req_on_i`=0) raises `done_o` with `fail_code_o`=0 and drops `busy_o` on the second edge after acceptance. It leaves `int_clk_en_o` and `clk_out_en_o` unchanged.
- R4: For an on request, `int_clk_en_o` rises on the second edge after acceptance. `clk_out_en_o` rises on the edge after the first later edge at which `clk_rdy_i` is sampled high.
- R5: If `clk_rdy_i` is sampled low on CLK_TMO consecutive edges after `int_clk_en_o` rises, the sequence fails with code 1.
- R6: `pdb_o` rises exactly SETTLE_CYC cycles after `clk_out_en_o` rises.
- R7: `cal_done_i` is sampled CAL_CYC cycles after `pdb_o` rises. If it is high, `endll_o` rises on that edge. If it is low, the sequence fails with code 2.
- R8: `dll_rdy_i` is sampled DLL_CYC cycles after `endll_o` rises. If it is high, `done_o` rises with code 0. If it is low, the sequence fails with code 3.
- R9: Result codes are 0 for success, 1 for clock not ready, 2 for calibration timeout and 3 for DLL timeout. On any failure, `pdb_o` and `endll_o` are low on the edge before `done_o` rises, and they stay low while the code is reported.
- R10: `done_o` and `fail_code_o` hold until the next accepted request. A request made while `busy_o` is high has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_stb_i | input | 1 | Request strobe, one cycle |
| req_on_i | input | 1 | Request direction: 1 power on, 0 power off |
| clk_rdy_i | input | 1 | Internal clock ready status |
| cal_done_i | input | 1 | Pad calibration finished status |
| dll_rdy_i | input | 1 | DLL locked status |
| int_clk_en_o | output | 1 | Internal clock enable |
| clk_out_en_o | output | 1 | Clock output enable |
| pdb_o | output | 1 | Power-down-bar to the analog PHY |
| endll_o | output | 1 | DLL enable |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence finished; held until the next request |
| fail_code_o | output | 2 | Result code, valid while done_o is high |

## Verification
A wrong internal state shows up at the ports as an enable that moves in the wrong cycle, or as a sequence that ends with the wrong code. The bench reference model predicts every output on every cycle, so a state or counter error is caught on the first cycle the outputs diverge. That is usually the edge where an interval should end, and at the latest when `done_o` rises. Directed runs drive each status input low at its sampling point in turn, and inject a request mid-sequence, so that every failure path and the drop rule are observed at the ports.

// File: rtl/phy_pwr_seq_pkg.sv
package phy_pwr_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_FORCE  = 3'd1,
    ST_CLKW   = 3'd2,
    ST_SETTLE = 3'd3,
    ST_CALW   = 3'd4,
    ST_DLLW   = 3'd5,
    ST_FAIL   = 3'd6
  } seq_state_t;

  localparam logic [1:0] CODE_OK  = 2'd0;
  localparam logic [1:0] CODE_CLK = 2'd1;
  localparam logic [1:0] CODE_CAL = 2'd2;
  localparam logic [1:0] CODE_DLL = 2'd3;
endpackage

// File: rtl/pwr_seq_timer.sv
module pwr_seq_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic             run_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= len_i - CNT_W'(1);
    end else if (run_i && cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign zero_o = (cnt_q == '0);

  // R6: an interval never counts up on its own
  a_r6_timer_monotone: assert property (@(posedge clk) disable iff (rst)
    (!load_i && $past(!load_i) && !$past(rst)) |-> (cnt_q <= $past(cnt_q)));
endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
  import phy_pwr_seq_pkg::*;
#(
  parameter int CLK_TMO    = 2000,
  parameter int SETTLE_CYC = 600,
  parameter int CAL_CYC    = 1000,
  parameter int DLL_CYC    = 5000,
  parameter int CNT_W      = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_stb_i,
  input  logic             req_on_i,
  input  logic             clk_rdy_i,
  input  logic             cal_done_i,
  input  logic             dll_rdy_i,
  input  logic             tmr_zero_i,
  output logic             tmr_load_o,
  output logic [CNT_W-1:0] tmr_len_o,
  output logic             tmr_run_o,
  output logic             int_clk_en_o,
  output logic             clk_out_en_o,
  output logic             pdb_o,
  output logic             endll_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [1:0]       fail_code_o
);
  seq_state_t state_q;
  logic       on_q;
  logic [1:0] code_q;

  // interval loads happen exactly on the transitions into a wait state
  always_comb begin
    tmr_load_o = 1'b0;
    tmr_len_o  = '0;
    unique case (state_q)
      ST_FORCE: if (on_q) begin
        tmr_load_o = 1'b1;
        tmr_len_o  = CNT_W'(CLK_TMO);
      end
      ST_CLKW: if (clk_rdy_i) begin
        tmr_load_o = 1'b1;
        tmr_len_o  = CNT_W'(SETTLE_CYC);
      end
      ST_SETTLE: if (tmr_zero_i) begin
        tmr_load_o = 1'b1;
        tmr_len_o  = CNT_W'(CAL_CYC);
      end
      ST_CALW: if (tmr_zero_i && cal_done_i) begin
        tmr_load_o = 1'b1;
        tmr_len_o  = CNT_W'(DLL_CYC);
      end
      default: ;
    endcase
  end

  assign tmr_run_o = (state_q == ST_CLKW) || (state_q == ST_SETTLE) ||
                     (state_q == ST_CALW) || (state_q == ST_DLLW);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      on_q         <= 1'b0;
      code_q       <= CODE_OK;
      int_clk_en_o <= 1'b0;
      clk_out_en_o <= 1'b0;
      pdb_o        <= 1'b0;
      endll_o      <= 1'b0;
      busy_o       <= 1'b0;
      done_o       <= 1'b0;
      fail_code_o  <= CODE_OK;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_stb_i) begin
          on_q        <= req_on_i;
          pdb_o       <= 1'b0;
          endll_o     <= 1'b0;
          busy_o      <= 1'b1;
          done_o      <= 1'b0;
          fail_code_o <= CODE_OK;
          if (req_on_i) clk_out_en_o <= 1'b0;
          state_q     <= ST_FORCE;
        end
        ST_FORCE: begin
          if (on_q) begin
            int_clk_en_o <= 1'b1;
            state_q      <= ST_CLKW;
          end else begin
            done_o  <= 1'b1;
            busy_o  <= 1'b0;
            state_q <= ST_IDLE;
          end
        end
        ST_CLKW: begin
          if (clk_rdy_i) begin
            clk_out_en_o <= 1'b1;
            state_q      <= ST_SETTLE;
          end else if (tmr_zero_i) begin
            code_q  <= CODE_CLK;
            state_q <= ST_FAIL;
          end
        end
        ST_SETTLE: if (tmr_zero_i) begin
          pdb_o   <= 1'b1;
          state_q <= ST_CALW;
        end
        ST_CALW: if (tmr_zero_i) begin
          if (cal_done_i) begin
            endll_o <= 1'b1;
            state_q <= ST_DLLW;
          end else begin
            pdb_o   <= 1'b0;
            endll_o <= 1'b0;
            code_q  <= CODE_CAL;
            state_q <= ST_FAIL;
          end
        end
        ST_DLLW: if (tmr_zero_i) begin
          if (dll_rdy_i) begin
            done_o  <= 1'b1;
            busy_o  <= 1'b0;
            state_q <= ST_IDLE;
          end else begin
            pdb_o   <= 1'b0;
            endll_o <= 1'b0;
            code_q  <= CODE_DLL;
            state_q <= ST_FAIL;
          end
        end
        ST_FAIL: begin
          done_o      <= 1'b1;
          fail_code_o <= code_q;
          busy_o      <= 1'b0;
          state_q     <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R2: an accepted request starts a sequence with the analog side held off
  a_r2_accept: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && req_stb_i) |=> (busy_o && !done_o && !pdb_o && !endll_o));
  // R9: a reported failure never leaves the analog side powered
  a_r9_fail_safe: assert property (@(posedge clk) disable iff (rst)
    (done_o && fail_code_o != CODE_OK) |-> (!pdb_o && !endll_o));
  // R6: power-down release only with both clocks running
  a_r6_pdb_clocked: assert property (@(posedge clk) disable iff (rst)
    $rose(pdb_o) |-> (int_clk_en_o && clk_out_en_o));
  // R7: DLL enable only after power-down is released
  a_r7_endll_order: assert property (@(posedge clk) disable iff (rst)
    endll_o |-> pdb_o);
  // R10: done and its code stay put while no request arrives
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (done_o && !req_stb_i) |=> (done_o && $stable(fail_code_o)));
  // R10: done and busy are exclusive
  a_r10_done_idle: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);
endmodule

// File: rtl/phy_pwr_seq.sv
module phy_pwr_seq #(
  parameter int CLK_TMO    = 2000,
  parameter int SETTLE_CYC = 600,
  parameter int CAL_CYC    = 1000,
  parameter int DLL_CYC    = 5000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req_stb_i,
  input  logic       req_on_i,
  input  logic       clk_rdy_i,
  input  logic       cal_done_i,
  input  logic       dll_rdy_i,
  output logic       int_clk_en_o,
  output logic       clk_out_en_o,
  output logic       pdb_o,
  output logic       endll_o,
  output logic       busy_o,
  output logic       done_o,
  output logic [1:0] fail_code_o
);
  localparam int MAX_A    = (CLK_TMO > SETTLE_CYC) ? CLK_TMO : SETTLE_CYC;
  localparam int MAX_B    = (CAL_CYC > DLL_CYC) ? CAL_CYC : DLL_CYC;
  localparam int MAX_WAIT = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W    = $clog2(MAX_WAIT + 1);

  logic             tmr_load;
  logic             tmr_run;
  logic             tmr_zero;
  logic [CNT_W-1:0] tmr_len;

  initial begin
    if (CLK_TMO < 1 || SETTLE_CYC < 1 || CAL_CYC < 1 || DLL_CYC < 1)
      $error("phy_pwr_seq: every interval must be at least one cycle");
  end

  pwr_seq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .load_i (tmr_load),
    .len_i  (tmr_len),
    .run_i  (tmr_run),
    .zero_o (tmr_zero)
  );

  pwr_seq_fsm #(
    .CLK_TMO    (CLK_TMO),
    .SETTLE_CYC (SETTLE_CYC),
    .CAL_CYC    (CAL_CYC),
    .DLL_CYC    (DLL_CYC),
    .CNT_W      (CNT_W)
  ) u_fsm (
    .clk          (clk),
    .rst          (rst),
    .req_stb_i    (req_stb_i),
    .req_on_i     (req_on_i),
    .clk_rdy_i    (clk_rdy_i),
    .cal_done_i   (cal_done_i),
    .dll_rdy_i    (dll_rdy_i),
    .tmr_zero_i   (tmr_zero),
    .tmr_load_o   (tmr_load),
    .tmr_len_o    (tmr_len),
    .tmr_run_o    (tmr_run),
    .int_clk_en_o (int_clk_en_o),
    .clk_out_en_o (clk_out_en_o),
    .pdb_o        (pdb_o),
    .endll_o      (endll_o),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .fail_code_o  (fail_code_o)
  );
endmodule

// File: tb/phy_pwr_seq_tb_top.sv
module phy_pwr_seq_tb_top;
  localparam int P_CLK = 8;
  localparam int P_SET = 5;
  localparam int P_CAL = 6;
  localparam int P_DLL = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_stb = 1'b0, req_on = 1'b0;
  logic clk_rdy = 1'b0, cal_done = 1'b0, dll_rdy = 1'b0;
  logic int_clk_en, clk_out_en, pdb, endll, busy, done;
  logic [1:0] code;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  phy_pwr_seq #(.CLK_TMO(P_CLK), .SETTLE_CYC(P_SET), .CAL_CYC(P_CAL),
                .DLL_CYC(P_DLL)) dut_i (
    .clk(clk), .rst(rst), .req_stb_i(req_stb), .req_on_i(req_on),
    .clk_rdy_i(clk_rdy), .cal_done_i(cal_done), .dll_rdy_i(dll_rdy),
    .int_clk_en_o(int_clk_en), .clk_out_en_o(clk_out_en), .pdb_o(pdb),
    .endll_o(endll), .busy_o(busy), .done_o(done), .fail_code_o(code));

  // behavioural reference: a step name plus an up-counting elapsed time
  string m_step = "idle";
  int    m_el = 0;
  bit    m_on = 0;
  int    m_pend = 0;
  bit    m_ice = 0, m_coe = 0, m_pdb = 0, m_dll = 0, m_busy = 0, m_done = 0;
  int    m_code = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_step = "idle"; m_el = 0; m_ice = 0; m_coe = 0; m_pdb = 0;
      m_dll = 0; m_busy = 0; m_done = 0; m_code = 0;
    end else if (m_step == "idle") begin
      if (req_stb) begin
        m_on = req_on; m_pdb = 0; m_dll = 0; m_busy = 1; m_done = 0;
        m_code = 0; if (req_on) m_coe = 0; m_step = "force";
      end
    end else if (m_step == "force") begin
      if (!m_on) begin m_done = 1; m_busy = 0; m_step = "idle"; end
      else begin m_ice = 1; m_el = 0; m_step = "clk"; end
    end else if (m_step == "clk") begin
      if (clk_rdy) begin m_coe = 1; m_el = 0; m_step = "settle"; end
      else if (++m_el == P_CLK) begin m_pend = 1; m_step = "fail"; end
    end else if (m_step == "settle") begin
      if (++m_el == P_SET) begin m_pdb = 1; m_el = 0; m_step = "cal"; end
    end else if (m_step == "cal") begin
      if (++m_el == P_CAL) begin
        m_el = 0;
        if (cal_done) begin m_dll = 1; m_step = "dll"; end
        else begin m_pdb = 0; m_pend = 2; m_step = "fail"; end
      end
    end else if (m_step == "dll") begin
      if (++m_el == P_DLL) begin
        if (dll_rdy) begin m_done = 1; m_busy = 0; m_step = "idle"; end
        else begin m_pdb = 0; m_dll = 0; m_pend = 3; m_step = "fail"; end
      end
    end else begin
      m_done = 1; m_code = m_pend; m_busy = 0; m_step = "idle";
    end
  end

  always @(negedge clk) begin
    cyc++;
    n_cmp++;
    if ({int_clk_en, clk_out_en, pdb, endll, busy, done} !==
        {m_ice, m_coe, m_pdb, m_dll, m_busy, m_done} || code !== 2'(m_code)) begin
      n_bad++;
      $display("FAIL model R2-R10 cycle %0d: got ice%b coe%b pdb%b dll%b busy%b done%b code%0d exp %b%b%b%b%b%b code%0d",
               cyc, int_clk_en, clk_out_en, pdb, endll, busy, done, code,
               m_ice, m_coe, m_pdb, m_dll, m_busy, m_done, m_code);
    end
  end

  task automatic chk(input string req, input int got, input int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic request(input bit on);
    req_stb = 1'b1; req_on = on;
    tick();
    req_stb = 1'b0;
  endtask

  task automatic wait_done(output int cycles);
    cycles = 0;
    while (!done && cycles < 200) begin tick(); cycles++; end
  endtask

  int t;
  bit pdb_prev;

  initial begin
    tick(3);
    rst = 1'b0;
    // R1 reset state
    chk("R1 outputs", {int_clk_en, clk_out_en, pdb, endll, busy, done}, 0);
    chk("R1 code", code, 0);

    // R2/R3 power-off
    request(1'b0);
    chk("R2 busy", busy, 1);
    chk("R2 pdb/endll", {pdb, endll}, 0);
    tick();
    chk("R3 done", done, 1);
    chk("R3 busy", busy, 0);
    chk("R3 code", code, 0);

    // R4, R6, R7, R8 full power-on, R10 drop of mid-run request
    cal_done = 1; dll_rdy = 1;
    request(1'b1);
    chk("R4 int clk not yet", int_clk_en, 0);
    tick();
    chk("R4 int clk", int_clk_en, 1);
    request(1'b0); // R10 ignored while busy
    chk("R10 busy kept", busy, 1);
    tick(2);
    chk("R4 clk out waits for ready", clk_out_en, 0);
    clk_rdy = 1;
    tick();
    chk("R4 clk out", clk_out_en, 1);
    t = 0; while (!pdb && t < 50) begin tick(); t++; end
    chk("R6 settle cycles", t, P_SET);
    t = 0; while (!endll && t < 50) begin tick(); t++; end
    chk("R7 cal cycles", t, P_CAL);
    t = 0; while (!done && t < 50) begin tick(); t++; end
    chk("R8 dll cycles", t, P_DLL);
    chk("R8 code ok", code, 0);
    chk("R10 mid-run off had no effect", {pdb, endll}, 2'b11);
    tick(5);
    chk("R10 done held", {done, code}, 3'b100);

    // R3 off after on keeps clocks
    request(1'b0);
    tick();
    chk("R3 off result", {done, pdb, endll}, 3'b100);
    chk("R3 clocks kept", {int_clk_en, clk_out_en}, 2'b11);

    // R5 clock timeout
    clk_rdy = 0;
    request(1'b1);
    wait_done(t);
    chk("R5 code", code, 1);
    chk("R9 clk fail safe", {pdb, endll}, 0);

    // R7 calibration failure
    clk_rdy = 1; cal_done = 0;
    request(1'b1);
    pdb_prev = 1'b1;
    t = 0;
    while (!done && t < 200) begin pdb_prev = pdb; tick(); t++; end
    chk("R7 cal fail code", code, 2);
    chk("R9 pdb low before done", pdb_prev, 0);

    // R8 DLL failure
    cal_done = 1; dll_rdy = 0;
    request(1'b1);
    wait_done(t);
    chk("R8 dll fail code", code, 3);
    chk("R9 dll fail safe", {pdb, endll}, 0);

    tick(2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(5 * 20000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule